// File: doc/BRIEF.md
# Miss-Dependent Dispatch Gating Unit

This unit sits at the dispatch stage of a multithreaded out-of-order core that runs each program as a leading copy and a trailing copy. It keeps one pending-miss bit for every physical rename register. The load pipeline sets a bit when a load that writes that register misses the data cache, or is predicted to miss when it leaves the instruction queue. The bit is cleared when the load returns its data or is squashed. An instruction that reads a register whose bit is set is not dispatched. The queue entries it would have held stay free for other threads.

Each cycle the unit looks at a window of the oldest instructions from every thread. It picks one thread in round-robin order and grants that thread a run of in-order instructions. The run is limited by the dispatch width and by the number of free instruction-queue entries. A miss does not stall a thread as a whole. Only the first instruction that depends on an unresolved miss stops the run, and the slot goes to the next eligible thread in the same cycle. Trailing copies take their load values from their leading copy, so they are never gated.

Top module: `mdg_dispatch_gate`

## Requirements
- R1: A set request on `miss_set_tag` raises that register's pending bit. Dispatch checks see the bit from the next cycle on, not in the cycle of the set.
- R2: A clear request (load data returned, or squash) lowers the pending bit. A dispatch check of the same register in the same cycle already sees it as clear.
- R3: When a set and a clear name the same register in one cycle, the bit ends low if the clear is a squash (`ld_clr_squash`=1). Otherwise it ends high.
- R4: A leading thread whose oldest valid head instruction reads a pending register (with its source-valid bit set) gets no grant. The grant goes, in the same cycle, to the next eligible thread in round-robin order.
- R5: Within the granted thread, the granted count equals the number of consecutive valid, unblocked head slots starting at slot 0, the oldest. A blocked or invalid slot ends the run even if younger slots are independent. Instructions that do not depend on the miss still dispatch.
- R6: The granted count never exceeds `iq_free_cnt` or DISPATCH_W. When `iq_free_cnt` is 0 there is no grant.
- R7: The search starts at the thread after the last granted one and wraps around. After reset, thread 0 has first priority. Cycles without a grant leave the pointer unchanged.
- R8: Odd-numbered threads are trailing copies, and pending bits never block them. Even-numbered threads are leading copies and are gated.
- R9: After reset all pending bits are clear. With no valid heads there is no grant. `gnt_thread` is zero or one-hot, and it matches `gnt_tid` whenever `gnt_vld` is 1.

Head packing: slot s of thread t is bit t*DISPATCH_W+s of `head_vld`. Its source j is field ((t*DISPATCH_W+s)*NUM_SRC+j) of width log2(NUM_PREGS) in `head_src_tag`, and bit (t*DISPATCH_W+s)*NUM_SRC+j of `head_src_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_set_vld | input | 1 | Load missed or is predicted to miss |
| miss_set_tag | input | TAGW | Destination register of that load |
| ld_clr_vld | input | 1 | Load resolved or squashed |
| ld_clr_tag | input | TAGW | Destination register being cleared |
| ld_clr_squash | input | 1 | Clear comes from a squash |
| head_vld | input | NUM_THREADS*DISPATCH_W | Head slot valid bits |
| head_src_tag | input | NUM_THREADS*DISPATCH_W*NUM_SRC*TAGW | Source physical tags |
| head_src_vld | input | NUM_THREADS*DISPATCH_W*NUM_SRC | Source used bits |
| iq_free_cnt | input | FREEW | Free instruction-queue entries |
| gnt_vld | output | 1 | A grant is made this cycle |
| gnt_thread | output | NUM_THREADS | One-hot granted thread |
| gnt_tid | output | TIDW | Granted thread index |
| gnt_cnt | output | CNTW | Number of head slots granted |

## Verification
The bench goes after the timing edges of the pending bit. A set must not block in its own cycle, and a same-cycle clear must unblock. A design that mistimes either would grant a dependent instruction too early or hold it one cycle too long. The bench also drives set/clear collisions of both kinds, where swapping the priority leaves a squashed register flagged forever or drops a live miss. It checks runs that break at a blocked middle slot, where a design that skips over the slot would let younger instructions go ahead of older ones. It checks trailing threads reading flagged registers, and tight free-entry counts. A long sweep with heavy tag reuse compares every grant against an arithmetic model. That sweep exposes pointer or wrap errors in the round-robin order.

// File: rtl/mdg_pkg.sv
`timescale 1ns/1ps
package mdg_pkg;

  // Smaller of the ready run length and the free queue entries.
  function automatic int unsigned clamp_grant(int unsigned ready, int unsigned room);
    return (ready < room) ? ready : room;
  endfunction

  // Next value of one pending-miss bit.
  function automatic logic next_pending(logic cur, logic set_hit, logic clr_hit, logic squash);
    if (set_hit && clr_hit) return !squash;
    if (set_hit)            return 1'b1;
    if (clr_hit)            return 1'b0;
    return cur;
  endfunction

  // Trailing copies sit on odd thread indices.
  function automatic bit is_leader(int tid);
    return (tid % 2) == 0;
  endfunction

endpackage

// File: rtl/mdg_flag_file.sv
`timescale 1ns/1ps
module mdg_flag_file #(
  parameter int NUM_PREGS = 64,
  localparam int TAGW = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_vld,
  input  logic [TAGW-1:0]      set_tag,
  input  logic                 clr_vld,
  input  logic [TAGW-1:0]      clr_tag,
  input  logic                 clr_squash,
  output logic [NUM_PREGS-1:0] pend_q,
  output logic [NUM_PREGS-1:0] pend_view
);
  for (genvar p = 0; p < NUM_PREGS; p++) begin : g_reg
    logic set_hit, clr_hit;
    assign set_hit = set_vld && (int'(set_tag) == p);
    assign clr_hit = clr_vld && (int'(clr_tag) == p);

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[p] <= 1'b0;
      else        pend_q[p] <= mdg_pkg::next_pending(pend_q[p], set_hit, clr_hit, clr_squash);
    end

    // Same-cycle clear is bypassed to the dispatch check; a set is not.
    assign pend_view[p] = pend_q[p] && !clr_hit;
  end
endmodule

// File: rtl/mdg_thread_ready.sv
`timescale 1ns/1ps
module mdg_thread_ready #(
  parameter int NUM_PREGS  = 64,
  parameter int DISPATCH_W = 4,
  parameter int NUM_SRC    = 2,
  parameter bit LEADER     = 1'b1,
  localparam int TAGW = $clog2(NUM_PREGS),
  localparam int CNTW = $clog2(DISPATCH_W + 1)
) (
  input  logic [DISPATCH_W-1:0]              hd_vld,
  input  logic [DISPATCH_W*NUM_SRC*TAGW-1:0] hd_src_tag,
  input  logic [DISPATCH_W*NUM_SRC-1:0]      hd_src_vld,
  input  logic [NUM_PREGS-1:0]               pend_view,
  output logic [CNTW-1:0]                    ready_cnt,
  output logic                               head_gated
);
  logic [DISPATCH_W-1:0] slot_blk;

  for (genvar s = 0; s < DISPATCH_W; s++) begin : g_slot
    always_comb begin
      logic hit;
      hit = 1'b0;
      for (int j = 0; j < NUM_SRC; j++) begin
        logic [TAGW-1:0] tg;
        tg = hd_src_tag[(s*NUM_SRC+j)*TAGW +: TAGW];
        if (hd_src_vld[s*NUM_SRC+j] && int'(tg) < NUM_PREGS && pend_view[tg]) hit = 1'b1;
      end
      slot_blk[s] = LEADER && hit;
    end
  end

  // In-order run: stop at the first invalid or blocked slot.
  always_comb begin
    logic open;
    open = 1'b1;
    ready_cnt = '0;
    for (int s = 0; s < DISPATCH_W; s++) begin
      if (open && hd_vld[s] && !slot_blk[s]) ready_cnt = ready_cnt + 1'b1;
      else open = 1'b0;
    end
  end

  assign head_gated = hd_vld[0] && slot_blk[0];
endmodule

// File: rtl/mdg_rr_pick.sv
`timescale 1ns/1ps
module mdg_rr_pick #(
  parameter int NUM_THREADS = 8,
  parameter int CNTW        = 3,
  localparam int TIDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS*CNTW-1:0] ready_bus,
  input  logic [TIDW-1:0]             last_q,
  input  logic                        enable,
  output logic                        pick_vld,
  output logic [TIDW-1:0]             pick_tid
);
  always_comb begin
    pick_vld = 1'b0;
    pick_tid = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      int c;
      c = int'(last_q) + k;
      if (c >= NUM_THREADS) c = c - NUM_THREADS;
      if (!pick_vld && enable && (ready_bus[c*CNTW +: CNTW] != '0)) begin
        pick_vld = 1'b1;
        pick_tid = TIDW'(c);
      end
    end
  end
endmodule

// File: rtl/mdg_dispatch_gate.sv
`timescale 1ns/1ps
module mdg_dispatch_gate #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_PREGS   = 64,
  parameter int IQ_DEPTH    = 32,
  parameter int DISPATCH_W  = 4,
  parameter int NUM_SRC     = 2,
  localparam int TAGW  = $clog2(NUM_PREGS),
  localparam int CNTW  = $clog2(DISPATCH_W + 1),
  localparam int FREEW = $clog2(IQ_DEPTH + 1),
  localparam int TIDW  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOTS = NUM_THREADS * DISPATCH_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           miss_set_vld,
  input  logic [TAGW-1:0]                miss_set_tag,
  input  logic                           ld_clr_vld,
  input  logic [TAGW-1:0]                ld_clr_tag,
  input  logic                           ld_clr_squash,
  input  logic [SLOTS-1:0]               head_vld,
  input  logic [SLOTS*NUM_SRC*TAGW-1:0]  head_src_tag,
  input  logic [SLOTS*NUM_SRC-1:0]       head_src_vld,
  input  logic [FREEW-1:0]               iq_free_cnt,
  output logic                           gnt_vld,
  output logic [NUM_THREADS-1:0]         gnt_thread,
  output logic [TIDW-1:0]                gnt_tid,
  output logic [CNTW-1:0]                gnt_cnt
);
  localparam int TSRC = DISPATCH_W * NUM_SRC;

  logic [NUM_PREGS-1:0]        pend_q, pend_view;
  logic [NUM_THREADS*CNTW-1:0] ready_bus;
  logic [NUM_THREADS-1:0]      head_gated;
  logic [TIDW-1:0]             last_q;
  logic                        pick_vld;
  logic [TIDW-1:0]             pick_tid;
  logic [CNTW-1:0]             sel_cnt;

  mdg_flag_file #(.NUM_PREGS(NUM_PREGS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_vld(miss_set_vld), .set_tag(miss_set_tag),
    .clr_vld(ld_clr_vld), .clr_tag(ld_clr_tag), .clr_squash(ld_clr_squash),
    .pend_q(pend_q), .pend_view(pend_view)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    mdg_thread_ready #(
      .NUM_PREGS(NUM_PREGS), .DISPATCH_W(DISPATCH_W), .NUM_SRC(NUM_SRC),
      .LEADER(mdg_pkg::is_leader(t))
    ) u_ready (
      .hd_vld     (head_vld[t*DISPATCH_W +: DISPATCH_W]),
      .hd_src_tag (head_src_tag[t*TSRC*TAGW +: TSRC*TAGW]),
      .hd_src_vld (head_src_vld[t*TSRC +: TSRC]),
      .pend_view  (pend_view),
      .ready_cnt  (ready_bus[t*CNTW +: CNTW]),
      .head_gated (head_gated[t])
    );
  end

  mdg_rr_pick #(.NUM_THREADS(NUM_THREADS), .CNTW(CNTW)) u_pick (
    .ready_bus(ready_bus), .last_q(last_q), .enable(iq_free_cnt != '0),
    .pick_vld(pick_vld), .pick_tid(pick_tid)
  );

  assign sel_cnt = ready_bus[int'(pick_tid)*CNTW +: CNTW];

  always_comb begin
    gnt_vld    = pick_vld;
    gnt_tid    = pick_tid;
    gnt_thread = '0;
    gnt_cnt    = '0;
    if (pick_vld) begin
      gnt_thread[pick_tid] = 1'b1;
      gnt_cnt = CNTW'(mdg_pkg::clamp_grant(int'(sel_cnt), int'(iq_free_cnt)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        last_q <= TIDW'(NUM_THREADS - 1);
    else if (pick_vld) last_q <= pick_tid;
  end
endmodule

// File: rtl/mdg_dispatch_gate_chk.sv
`timescale 1ns/1ps
module mdg_dispatch_gate_chk #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_PREGS   = 64,
  parameter int DISPATCH_W  = 4,
  parameter int TAGW        = 6,
  parameter int CNTW        = 3,
  parameter int FREEW       = 6,
  parameter int TIDW        = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   miss_set_vld,
  input logic [TAGW-1:0]        miss_set_tag,
  input logic                   ld_clr_vld,
  input logic [TAGW-1:0]        ld_clr_tag,
  input logic                   ld_clr_squash,
  input logic [FREEW-1:0]       iq_free_cnt,
  input logic                   gnt_vld,
  input logic [NUM_THREADS-1:0] gnt_thread,
  input logic [TIDW-1:0]        gnt_tid,
  input logic [CNTW-1:0]        gnt_cnt,
  input logic [NUM_PREGS-1:0]   pend_q,
  input logic [NUM_THREADS-1:0] head_gated
);
  logic same_tag;
  assign same_tag = miss_set_vld && ld_clr_vld && (miss_set_tag == ld_clr_tag);

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_set_vld && !(same_tag && ld_clr_squash)) |=> pend_q[$past(miss_set_tag)]);

  assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_clr_vld && !(same_tag && !ld_clr_squash)) |=> !pend_q[$past(ld_clr_tag)]);

  assert_collide_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (same_tag && !ld_clr_squash) |=> pend_q[$past(miss_set_tag)]);

  assert_gated_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> !head_gated[gnt_tid]);

  assert_grant_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (gnt_cnt != '0 && int'(gnt_cnt) <= int'(iq_free_cnt) && int'(gnt_cnt) <= DISPATCH_W));

  assert_full_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_free_cnt == '0) |-> !gnt_vld);

  assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_thread) && (gnt_vld == (gnt_thread != '0)));

  for (genvar t = 1; t < NUM_THREADS; t += 2) begin : g_trail
    assert_trailing_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !head_gated[t]);
  end
endmodule

bind mdg_dispatch_gate mdg_dispatch_gate_chk #(
  .NUM_THREADS(NUM_THREADS), .NUM_PREGS(NUM_PREGS), .DISPATCH_W(DISPATCH_W),
  .TAGW(TAGW), .CNTW(CNTW), .FREEW(FREEW), .TIDW(TIDW)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .miss_set_vld(miss_set_vld), .miss_set_tag(miss_set_tag),
  .ld_clr_vld(ld_clr_vld), .ld_clr_tag(ld_clr_tag), .ld_clr_squash(ld_clr_squash),
  .iq_free_cnt(iq_free_cnt),
  .gnt_vld(gnt_vld), .gnt_thread(gnt_thread), .gnt_tid(gnt_tid), .gnt_cnt(gnt_cnt),
  .pend_q(pend_q), .head_gated(head_gated)
);

// File: tb/mdg_dispatch_gate_bench.sv
`timescale 1ns/1ps
module mdg_dispatch_gate_bench;
  localparam int T = 8, P = 64, Q = 32, W = 4, S = 2;
  localparam int TW = 6, CW = 3, FW = 6, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_set_vld = 0, ld_clr_vld = 0, ld_clr_squash = 0;
  logic [TW-1:0] miss_set_tag = '0, ld_clr_tag = '0;
  logic [T*W-1:0] head_vld = '0;
  logic [T*W*S*TW-1:0] head_src_tag = '0;
  logic [T*W*S-1:0] head_src_vld = '0;
  logic [FW-1:0] iq_free_cnt = '0;
  logic gnt_vld;
  logic [T-1:0] gnt_thread;
  logic [IW-1:0] gnt_tid;
  logic [CW-1:0] gnt_cnt;

  int checks = 0, errors = 0;
  bit done = 0;
  bit [P-1:0] m_pend;
  int m_last;

  always #4 clk = ~clk;

  mdg_dispatch_gate u_mdg_dispatch_gate (
    .clk(clk), .rst_n(rst_n),
    .miss_set_vld(miss_set_vld), .miss_set_tag(miss_set_tag),
    .ld_clr_vld(ld_clr_vld), .ld_clr_tag(ld_clr_tag), .ld_clr_squash(ld_clr_squash),
    .head_vld(head_vld), .head_src_tag(head_src_tag), .head_src_vld(head_src_vld),
    .iq_free_cnt(iq_free_cnt),
    .gnt_vld(gnt_vld), .gnt_thread(gnt_thread), .gnt_tid(gnt_tid), .gnt_cnt(gnt_cnt)
  );

  task automatic clear_heads();
    head_vld = '0; head_src_tag = '0; head_src_vld = '0;
  endtask

  task automatic put(int t, int s, int a, bit av, int b, bit bv);
    int i;
    i = t*W + s;
    head_vld[i] = 1'b1;
    head_src_tag[(i*S+0)*TW +: TW] = TW'(a);
    head_src_tag[(i*S+1)*TW +: TW] = TW'(b);
    head_src_vld[i*S+0] = av;
    head_src_vld[i*S+1] = bv;
  endtask

  function automatic bit seen_pending(int tag);
    return m_pend[tag] && !(ld_clr_vld && int'(ld_clr_tag) == tag);
  endfunction

  function automatic int run_len(int t);
    int n = 0;
    for (int s = 0; s < W; s++) begin
      int i = t*W + s;
      bit blk = 0;
      if (!head_vld[i]) break;
      if (t % 2 == 0)
        for (int j = 0; j < S; j++)
          if (head_src_vld[i*S+j] && seen_pending(int'(head_src_tag[(i*S+j)*TW +: TW]))) blk = 1;
      if (blk) break;
      n++;
    end
    return n;
  endfunction

  // Called after inputs settle, before the next rising edge.
  task automatic step(string req);
    int e_tid, e_cnt;
    bit e_vld;
    logic [T-1:0] e_oh;
    #2;
    e_vld = 0; e_tid = 0; e_cnt = 0;
    if (iq_free_cnt != 0)
      for (int k = 1; k <= T; k++) begin
        int c = (m_last + k) % T;
        int n = run_len(c);
        if (!e_vld && n > 0) begin
          e_vld = 1; e_tid = c;
          e_cnt = (n < int'(iq_free_cnt)) ? n : int'(iq_free_cnt);
        end
      end
    e_oh = e_vld ? (T'(1) << e_tid) : '0;
    checks++;
    if (gnt_vld !== e_vld || gnt_thread !== e_oh || (e_vld && (int'(gnt_tid) != e_tid || int'(gnt_cnt) != e_cnt))) begin
      errors++;
      $display("FAIL %s: got vld=%0b thr=%b tid=%0d cnt=%0d, expected vld=%0b thr=%b tid=%0d cnt=%0d",
               req, gnt_vld, gnt_thread, gnt_tid, gnt_cnt, e_vld, e_oh, e_tid, e_cnt);
    end
    @(posedge clk);
    if (miss_set_vld && ld_clr_vld && miss_set_tag == ld_clr_tag) m_pend[miss_set_tag] = !ld_clr_squash;
    else begin
      if (miss_set_vld) m_pend[miss_set_tag] = 1'b1;
      if (ld_clr_vld)   m_pend[ld_clr_tag]   = 1'b0;
    end
    if (e_vld) m_last = e_tid;
    @(negedge clk);
    miss_set_vld = 0; ld_clr_vld = 0; ld_clr_squash = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    m_pend = '0; m_last = T - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    iq_free_cnt = 8;

    // R9: reset state, nothing valid
    step("R9");

    // R1: set visible only from next cycle
    put(0, 0, 5, 1, 0, 0);
    miss_set_vld = 1; miss_set_tag = 5;
    step("R1");
    put(2, 0, 7, 1, 0, 0);
    step("R1");                       // R4 also: thread 0 gated, thread 2 wins
    step("R4");

    // R2: same-cycle clear is bypassed
    ld_clr_vld = 1; ld_clr_tag = 5;
    step("R2");
    clear_heads();

    // R3: collision, completion keeps bit; squash drops it
    miss_set_vld = 1; miss_set_tag = 9; ld_clr_vld = 1; ld_clr_tag = 9;
    step("R3");
    put(0, 0, 1, 1, 9, 1);
    step("R3");
    miss_set_vld = 1; miss_set_tag = 9; ld_clr_vld = 1; ld_clr_tag = 9; ld_clr_squash = 1;
    clear_heads();
    step("R3");
    put(0, 0, 1, 1, 9, 1);
    step("R3");
    clear_heads();

    // R8: trailing thread not gated by a flagged source
    miss_set_vld = 1; miss_set_tag = 12;
    step("R8");
    put(0, 0, 12, 1, 0, 0);
    put(1, 0, 12, 1, 12, 1);
    step("R8");
    clear_heads();

    // R5: run ends at blocked middle slot, unused source ignored
    put(0, 0, 3, 1, 12, 0);
    put(0, 1, 12, 1, 4, 1);
    put(0, 2, 2, 1, 3, 1);
    put(0, 3, 2, 1, 3, 1);
    step("R5");
    put(0, 1, 13, 1, 4, 1);
    step("R5");
    clear_heads();
    put(4, 0, 1, 0, 1, 0); put(4, 2, 1, 0, 1, 0);
    step("R5");

    // R6: free entries limit the count
    clear_heads();
    for (int s = 0; s < W; s++) put(2, s, 20, 1, 21, 1);
    iq_free_cnt = 2; step("R6");
    iq_free_cnt = 0; step("R6");
    iq_free_cnt = 1; step("R6");
    iq_free_cnt = 32; step("R6");

    // R7: all threads ready, rotation and wrap
    clear_heads();
    for (int t = 0; t < T; t++) put(t, 0, 30, 1, 31, 1);
    for (int r = 0; r < 2*T + 3; r++) step("R7");
    iq_free_cnt = 0; step("R7");
    iq_free_cnt = 4; step("R7");

    // Sweep with a small tag pool so sets, clears and reads collide
    for (int c = 0; c < 4000; c++) begin
      clear_heads();
      for (int t = 0; t < T; t++)
        for (int s = 0; s < W; s++)
          if ($urandom_range(0, 4) != 0)
            put(t, s, $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                $urandom_range(0, 7), 1'($urandom_range(0, 1)));
      miss_set_vld = 1'($urandom_range(0, 1));
      miss_set_tag = TW'($urandom_range(0, 7));
      ld_clr_vld = 1'($urandom_range(0, 1));
      ld_clr_tag = TW'($urandom_range(0, 7));
      ld_clr_squash = 1'($urandom_range(0, 1));
      iq_free_cnt = FW'($urandom_range(0, 5));
      step("R4/R5/R6/R7");
    end
    finish_run();
  end
endmodule